// File: doc/BRIEF.md
# Nibble-Addressed DAC Input Register

This block is the digital front end of a 12-bit parallel-input digital-to-analog converter. A host with an 8-bit data bus builds a 12-bit code in three 4-bit pieces. Two address lines pick one of three nibble input latches. The high and low nibbles both take their data from bus lines 0 to 3, and the middle nibble takes its data from lines 4 to 7. A write happens when chip-select and write are both low.

A separate active-low load strobe copies the assembled input word into the DAC register, which drives the converter code. The load can be issued on its own. It can also fire in the same cycle as a high-nibble write, so that the converter jumps straight to the new full code.

An asynchronous clear input and a power-on reset both force every latch and the DAC register to zero. All strobes are sampled on the rising edge of the system clock. The block brings out both the DAC register and the input word.

Top module: `dac_nib_front`

## Requirements
- R1: While `clr_n` is low, `in_word` and `dac_code` are zero, whatever the other inputs are. Clear acts without waiting for a clock edge.
- R2: With `cs_n`=0, `wr_n`=0, `ld_n`=1 and `addr`=3, the clock edge loads `data[3:0]` into `in_word[11:8]`. The other bits and `dac_code` do not change.
- R3: With `cs_n`=0, `wr_n`=0, `ld_n`=1 and `addr`=2, the clock edge loads `data[7:4]` into `in_word[7:4]`. The other bits and `dac_code` do not change.
- R4: With `cs_n`=0, `wr_n`=0, `ld_n`=1 and `addr`=1, the clock edge loads `data[3:0]` into `in_word[3:0]`. The other bits and `dac_code` do not change.
- R5: With `cs_n`=1, `wr_n`=1 and `ld_n`=0, the clock edge copies `in_word` into `dac_code`, and `in_word` does not change.
- R6: With `ld_n`=1 and either `cs_n`=1 or `wr_n`=1, neither `in_word` nor `dac_code` changes.
- R7: With `cs_n`=0, `wr_n`=0 and `addr`=0, neither `dac_code` nor `in_word` changes, whatever the value of `ld_n`.
- R8: With `cs_n`, `wr_n` and `ld_n` all 0 and `addr`=3, a single clock edge loads the high nibble and sets `dac_code` to {`data[3:0]`, held `in_word[7:0]`}.
- R9: While `rst_n` (power-on reset) is low, `in_word` and `dac_code` are zero.
- R10: With `cs_n`=0, `wr_n`=0, `ld_n`=0 and `addr` equal to 2 or 1, only the selected nibble is written, and `dac_code` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_n | input | 1 | Clear, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | DAC-register load strobe, active low |
| addr | input | 2 | Nibble address: 3 high, 2 middle, 1 low, 0 none |
| data | input | 8 | Shared data bus |
| in_word | output | 12 | Assembled input-latch word |
| dac_code | output | 12 | DAC register, the converter code |

## Verification
The checker tests these rules on every clock edge: the cycle-to-cycle rules for nibble writes, the load-only transfer, the idle and address-0 cases, and the combined high-write-and-load. It also checks that both words are zero while clear or reset is held. Some properties need directed stimulus instead, and only the bench scenarios can show them. These are that clear acts between clock edges without waiting for one, that a sequence of partial writes builds the expected word, and that a load after such a sequence moves exactly that word to the output.

// File: rtl/dac_nib_pkg.sv
package dac_nib_pkg;

   // Control decoded from one cycle of strobes
   typedef struct packed {
      logic       wr_act;   // chip-select and write both asserted
      logic       xfer;     // DAC register takes the next input word
   } dac_nib_ctl_t;

   // Bus lane that feeds nibble idx when lanes are reused round-robin
   function automatic int unsigned lane_of(input int unsigned idx,
                                           input int unsigned lanes);
      return idx % lanes;
   endfunction

endpackage

// File: rtl/dac_nib_decode.sv
module dac_nib_decode
   import dac_nib_pkg::*;
#(
   parameter int unsigned NUM_NIB = 3,
   parameter int unsigned ADDR_W  = 2,
   parameter bit          LOAD_WITH_TOP = 1'b1
) (
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_NIB-1:0] nib_we,
   output dac_nib_ctl_t      ctl
);

   localparam logic [ADDR_W-1:0] TOP_CODE = ADDR_W'(NUM_NIB);

   logic wr_act;
   logic top_sel;

   assign wr_act  = !cs_n && !wr_n;
   assign top_sel = (addr == TOP_CODE);

   // address value i+1 selects nibble i; value 0 selects nothing
   for (genvar i = 0; i < NUM_NIB; i++) begin : g_we
      localparam logic [ADDR_W-1:0] CODE = ADDR_W'(i + 1);
      assign nib_we[i] = wr_act && (addr == CODE);
   end

   // transfer rule: a plain load when no write is in progress,
   // or a load merged with a write of the top nibble
   if (LOAD_WITH_TOP) begin : g_merge
      always_comb begin
         ctl.wr_act = wr_act;
         ctl.xfer   = !ld_n && (!wr_act || top_sel);
      end
   end else begin : g_plain
      always_comb begin
         ctl.wr_act = wr_act;
         ctl.xfer   = !ld_n && !wr_act;
      end
   end

endmodule

// File: rtl/dac_nib_latch.sv
module dac_nib_latch #(
   parameter int unsigned NIB_W = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             we,
   input  logic [NIB_W-1:0] din,
   output logic [NIB_W-1:0] q,
   output logic [NIB_W-1:0] q_next
);

   assign q_next = we ? din : q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) q <= '0;
      else         q <= q_next;
   end

endmodule

// File: rtl/dac_nib_xfer.sv
module dac_nib_xfer #(
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              xfer,
   input  logic [WORD_W-1:0] word_next,
   output logic [WORD_W-1:0] code
);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)   code <= '0;
      else if (xfer) code <= word_next;
   end

endmodule

// File: rtl/dac_nib_front.sv
module dac_nib_front
   import dac_nib_pkg::*;
#(
   parameter int unsigned NIB_W   = 4,
   parameter int unsigned NUM_NIB = 3,
   parameter int unsigned BUS_W   = 8,
   parameter int unsigned ADDR_W  = 2,
   parameter bit          LOAD_WITH_TOP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_n,
   input  logic                     cs_n,
   input  logic                     wr_n,
   input  logic                     ld_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [BUS_W-1:0]         data,
   output logic [NIB_W*NUM_NIB-1:0] in_word,
   output logic [NIB_W*NUM_NIB-1:0] dac_code
);

   localparam int unsigned WORD_W = NIB_W * NUM_NIB;
   localparam int unsigned LANES  = BUS_W / NIB_W;

   if (BUS_W % NIB_W != 0) begin : g_chk_bus
      $error("bus width must be a whole number of nibbles");
   end
   if (LANES < 1 || LANES > NUM_NIB) begin : g_chk_lanes
      $error("lane count must lie between 1 and the nibble count");
   end
   if ((1 << ADDR_W) <= NUM_NIB) begin : g_chk_addr
      $error("address too narrow for nibble count plus null code");
   end

   logic               arst_n;
   logic [NUM_NIB-1:0] nib_we;
   dac_nib_ctl_t       ctl;
   logic [WORD_W-1:0]  word_next;

   // power-on reset and clear share one asynchronous path
   assign arst_n = rst_n && clr_n;

   dac_nib_decode #(
      .NUM_NIB(NUM_NIB), .ADDR_W(ADDR_W), .LOAD_WITH_TOP(LOAD_WITH_TOP)
   ) u_dec (
      .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .addr(addr),
      .nib_we(nib_we), .ctl(ctl)
   );

   for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
      localparam int unsigned LANE = lane_of(i, LANES);
      dac_nib_latch #(.NIB_W(NIB_W)) u_lat (
         .clk(clk), .arst_n(arst_n), .we(nib_we[i]),
         .din(data[LANE*NIB_W +: NIB_W]),
         .q(in_word[i*NIB_W +: NIB_W]),
         .q_next(word_next[i*NIB_W +: NIB_W])
      );
   end

   dac_nib_xfer #(.WORD_W(WORD_W)) u_dac (
      .clk(clk), .arst_n(arst_n), .xfer(ctl.xfer),
      .word_next(word_next), .code(dac_code)
   );

endmodule

// File: rtl/dac_nib_front_chk.sv
module dac_nib_front_chk #(
   parameter int unsigned NIB_W   = 4,
   parameter int unsigned NUM_NIB = 3,
   parameter int unsigned BUS_W   = 8,
   parameter int unsigned ADDR_W  = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     clr_n,
   input logic                     cs_n,
   input logic                     wr_n,
   input logic                     ld_n,
   input logic [ADDR_W-1:0]        addr,
   input logic [BUS_W-1:0]         data,
   input logic [NIB_W*NUM_NIB-1:0] in_word,
   input logic [NIB_W*NUM_NIB-1:0] dac_code
);

   localparam int unsigned W = NIB_W * NUM_NIB;
   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(NUM_NIB);

   logic wr_act;
   assign wr_act = !cs_n && !wr_n;

   a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (in_word == '0 && dac_code == '0));

   a_r9_por_zero: assert property (@(posedge clk)
      !rst_n |-> (in_word == '0 && dac_code == '0));

   a_r2_top_write: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && wr_act && ld_n && addr == TOP) |=>
      (!clr_n || (in_word[W-1 -: NIB_W] == $past(data[NIB_W-1:0])
                  && $stable(in_word[W-NIB_W-1:0]) && $stable(dac_code))));

   a_r3_mid_write: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && wr_act && ld_n && addr == ADDR_W'(2)) |=>
      (!clr_n || (in_word[2*NIB_W-1 -: NIB_W] == $past(data[2*NIB_W-1:NIB_W])
                  && $stable(dac_code))));

   a_r5_load_only: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && cs_n && wr_n && !ld_n) |=>
      (!clr_n || (dac_code == $past(in_word) && $stable(in_word))));

   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !wr_act && ld_n) |=>
      (!clr_n || ($stable(in_word) && $stable(dac_code))));

   a_r7_null_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && wr_act && addr == '0) |=>
      (!clr_n || ($stable(in_word) && $stable(dac_code))));

   a_r8_merged_load: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && wr_act && !ld_n && addr == TOP) |=>
      (!clr_n || dac_code == {$past(data[NIB_W-1:0]), $past(in_word[W-NIB_W-1:0])}));

   a_r10_partial_no_dac: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && wr_act && !ld_n && addr != TOP && addr != '0) |=>
      (!clr_n || $stable(dac_code)));

endmodule

bind dac_nib_front dac_nib_front_chk #(
   .NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
   .ld_n(ld_n), .addr(addr), .data(data), .in_word(in_word),
   .dac_code(dac_code)
);

// File: tb/tb_dac_nib_front.sv
module tb_dac_nib_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_n = 1'b1;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        ld_n = 1'b1;
   logic [1:0]  addr = 2'd0;
   logic [7:0]  data = 8'h00;
   logic [11:0] in_word;
   logic [11:0] dac_code;

   logic [11:0] m_in  = 12'h000;
   logic [11:0] m_dac = 12'h000;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dac_nib_front dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
      .ld_n(ld_n), .addr(addr), .data(data), .in_word(in_word),
      .dac_code(dac_code)
   );

   task automatic check(input string req, input logic [11:0] act,
                        input logic [11:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%03h expected=%03h", req, what, act, exp);
      end
   endtask

   task automatic check_both(input string req);
      check(req, in_word, m_in, "in_word");
      check(req, dac_code, m_dac, "dac_code");
   endtask

   // One bus cycle: inputs change at the falling edge, results are read just after the rising edge.
   // Expected state follows the requirement table.
   task automatic bus_op(input bit c, input bit w, input bit l,
                         input logic [1:0] a, input logic [7:0] d);
      logic [11:0] nxt;
      @(negedge clk);
      cs_n = c; wr_n = w; ld_n = l; addr = a; data = d;
      nxt = m_in;
      if (!c && !w) begin
         case (a)
            2'd3: nxt[11:8] = d[3:0];
            2'd2: nxt[7:4]  = d[7:4];
            2'd1: nxt[3:0]  = d[3:0];
            default: ;
         endcase
         if (!l && a == 2'd3) m_dac = nxt;
      end else if (!l) begin
         m_dac = m_in;
      end
      m_in = nxt;
      @(posedge clk);
      #2;
      cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic t_reset;
      check_both("R9");
      check("R9", in_word, 12'h000, "in_word after reset");
   endtask

   task automatic t_high;
      bus_op(0, 0, 1, 2'd3, 8'hA5);
      check_both("R2");
      check("R2", in_word, 12'h500, "high nibble");
   endtask

   task automatic t_mid;
      bus_op(0, 0, 1, 2'd2, 8'hC3);
      check_both("R3");
      check("R3", in_word, 12'h5C0, "mid nibble");
   endtask

   task automatic t_low;
      bus_op(0, 0, 1, 2'd1, 8'h7E);
      check_both("R4");
      check("R4", in_word, 12'h5CE, "low nibble");
      check("R4", dac_code, 12'h000, "dac untouched");
   endtask

   task automatic t_load;
      bus_op(1, 1, 0, 2'd1, 8'hFF);
      check_both("R5");
      check("R5", dac_code, 12'h5CE, "loaded code");
   endtask

   task automatic t_idle;
      bus_op(1, 0, 1, 2'd3, 8'h11);
      check_both("R6");
      bus_op(0, 1, 1, 2'd2, 8'h22);
      check_both("R6");
      check("R6", in_word, 12'h5CE, "held word");
   endtask

   task automatic t_null;
      bus_op(0, 0, 0, 2'd0, 8'h99);
      check_both("R7");
      bus_op(0, 0, 1, 2'd0, 8'h66);
      check_both("R7");
      check("R7", dac_code, 12'h5CE, "dac held");
   endtask

   task automatic t_merge;
      bus_op(0, 0, 0, 2'd3, 8'h03);
      check_both("R8");
      check("R8", dac_code, 12'h3CE, "merged load");
   endtask

   task automatic t_partial;
      bus_op(0, 0, 0, 2'd2, 8'h40);
      check_both("R10");
      bus_op(0, 0, 0, 2'd1, 8'h09);
      check_both("R10");
      check("R10", dac_code, 12'h3CE, "dac unchanged");
      check("R10", in_word, 12'h349, "nibbles written");
   endtask

   task automatic t_clear;
      @(negedge clk);
      #3;
      clr_n = 1'b0;
      #2;   // no clock edge in between
      m_in = 12'h000; m_dac = 12'h000;
      check_both("R1");
      // strobes during clear have no effect
      cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0; addr = 2'd3; data = 8'hFF;
      @(posedge clk);
      #2;
      check_both("R1");
      cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
      @(negedge clk);
      clr_n = 1'b1;
   endtask

   task automatic t_por;
      bus_op(0, 0, 0, 2'd3, 8'h0B);
      check_both("R8");
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      m_in = 12'h000; m_dac = 12'h000;
      check_both("R9");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      t_reset();
      t_high();
      t_mid();
      t_low();
      t_load();
      t_idle();
      t_null();
      t_merge();
      t_partial();
      t_clear();
      t_por();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule